// File: doc/BRIEF.md
# Local Interrupt Timer

This block is a countdown timer for one processor. It requests a local interrupt through its own vector entry when the count runs out. Software programs it through a small register-write port. The port reaches four registers: the vector entry, the divide configuration, the initial count, and the read-only current count. A separate combinational read port returns any of the four.

A write of a nonzero initial count loads the counter and starts it. The counter then steps down once per prescaler period. The period length comes from a three-bit divide code. When the count reaches zero, the block raises a one-cycle request that carries the programmed vector, unless the entry is masked. The timer can run once or repeat. The vector entry's mode field also has a deadline code and a reserved code. Both are decoded, and both leave the counter frozen and silent.

Top module: `cpu_local_timer`

## Requirements
- R1: After reset the vector entry reads 0x0001_0000 (masked, vector 0, one-shot), and the divide configuration, initial count and current count all read zero.
- R2: Select code 0 is the vector entry. Bits 7:0 (vector), bit 16 (mask) and bits 18:17 (mode) are writable. Every other bit reads zero, including bit 12, the delivery-status bit, which ignores writes.
- R3: Select code 1 is the divide configuration. Only bits 0, 1 and 3 store a value, and all other bits read zero.
- R4: The divide code is {bit3, bit1, bit0}. The shift is (code + 1) modulo 8. The counter steps once every 2^shift clocks, so code 7 steps on every clock.
- R5: Select code 2 is the initial count, a full 32-bit read/write register. A nonzero write loads the current count on the same edge. The first decrement follows 2^shift clocks later.
- R6: Writing zero to the initial count stops the timer, clears the current count and prevents any further request.
- R7: In one-shot mode (mode 0), the request appears exactly N·2^shift clocks after the loading edge, and the counter then stays at zero.
- R8: In periodic mode (mode 1), the counter reloads the initial count on the edge where it reaches zero. Requests repeat every N·2^shift clocks.
- R9: A request is a single-cycle pulse carrying the vector field. While the mask bit is set, the counter still runs but no request is raised.
- R10: A change to the divide configuration takes effect at the next prescaler boundary and does not reset the current count.
- R11: With mode 2 (deadline) or mode 3 (reserved), the counter holds its value and raises no request. Switching back to mode 0 or 1 resumes the countdown.
- R12: Select code 3 reads the current count. Writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regWrSel | input | 2 | Write register select (0 vector, 1 divide, 2 initial, 3 current) |
| regWrData | input | 32 | Write data |
| regRdSel | input | 2 | Read register select, same codes |
| regRdData | output | 32 | Combinational read data |
| irqValid | output | 1 | One-cycle interrupt request |
| irqVector | output | 8 | Vector carried with the request |

## Verification
Several internal faults would show at the ports. A wrong prescaler limit or a badly latched shift moves the request edge by whole prescaler periods, and the bench detects this on the exact clock it predicts. A reload fault in periodic mode shows as a missing or early second request. A faulty zero-hold in one-shot mode shows as a stray later request or a nonzero current count. Mask and mode gating faults show as an unexpected pulse within N·2^shift cycles of the load, or as a current count that moves while the counter should be frozen.

// File: rtl/cpu_local_timer_pkg.sv
package cpu_local_timer_pkg;
  localparam int REG_W = 32;
  localparam int VEC_W = 8;
  localparam int DIV_CODE_W = 3;

  typedef enum logic [1:0] {
    SEL_VEC  = 2'd0,
    SEL_DIV  = 2'd1,
    SEL_INIT = 2'd2,
    SEL_CUR  = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    MODE_ONESHOT  = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_DEADLINE = 2'd2,
    MODE_RSVD     = 2'd3
  } timerMode_e;

  typedef struct packed {
    logic load;
    logic clear;
    logic tick;
  } ctrlStrobe_t;

  typedef struct packed {
    logic [VEC_W-1:0] vecNum;
    logic             vecMask;
    timerMode_e       mode;
  } timerCfg_t;
endpackage

// File: rtl/cpu_local_timer_ctrl.sv
module cpu_local_timer_ctrl
  import cpu_local_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [1:0]           regWrSel,
  input  logic [REG_W-1:0]     regWrData,
  input  logic [1:0]           regRdSel,
  input  logic [CNT_W-1:0]     curCount,
  output ctrlStrobe_t          strobe,
  output timerCfg_t            cfg,
  output logic [CNT_W-1:0]     initCount,
  output logic [REG_W-1:0]     regRdData
);
  localparam int PRE_W = (1 << DIV_CODE_W) - 1;

  logic [VEC_W-1:0]      vecNum;
  logic                  vecMask;
  timerMode_e            vecMode;
  logic [DIV_CODE_W-1:0] divBits;
  logic [DIV_CODE_W-1:0] cfgShift;
  logic [DIV_CODE_W-1:0] activeShift;
  logic [PRE_W-1:0]      preCnt;
  logic [PRE_W-1:0]      preLimit;
  logic                  wrVec, wrDiv, wrInit;
  logic                  modeActive, running, atBoundary;

  always_comb begin
    wrVec  = regWrEn && (regSel_e'(regWrSel) == SEL_VEC);
    wrDiv  = regWrEn && (regSel_e'(regWrSel) == SEL_DIV);
    wrInit = regWrEn && (regSel_e'(regWrSel) == SEL_INIT);
  end

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecNum    <= '0;
      vecMask   <= 1'b1;
      vecMode   <= MODE_ONESHOT;
      divBits   <= '0;
      initCount <= '0;
    end else begin
      if (wrVec) begin
        vecNum  <= regWrData[VEC_W-1:0];
        vecMask <= regWrData[16];
        vecMode <= timerMode_e'(regWrData[18:17]);
      end
      if (wrDiv) begin
        divBits <= {regWrData[3], regWrData[1:0]};
      end
      if (wrInit) begin
        initCount <= regWrData[CNT_W-1:0];
      end
    end
  end

  // divide code to shift: add one and wrap
  assign cfgShift = divBits + DIV_CODE_W'(1);

  always_comb begin
    modeActive = (vecMode == MODE_ONESHOT) || (vecMode == MODE_PERIODIC);
    running    = (curCount != '0) && modeActive;
    preLimit   = PRE_W'((32'd1 << activeShift) - 32'd1);
    atBoundary = (preCnt == preLimit);
  end

  // prescaler with a shift that is latched only at period boundaries
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt      <= '0;
      activeShift <= '0;
    end else if (wrInit || !running) begin
      preCnt      <= '0;
      activeShift <= cfgShift;
    end else if (atBoundary) begin
      preCnt      <= '0;
      activeShift <= cfgShift;
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end

  always_comb begin
    strobe.load  = wrInit && (regWrData[CNT_W-1:0] != '0);
    strobe.clear = wrInit && (regWrData[CNT_W-1:0] == '0);
    strobe.tick  = running && atBoundary && !wrInit;
    cfg.vecNum   = vecNum;
    cfg.vecMask  = vecMask;
    cfg.mode     = vecMode;
  end

  // read mux; delivery status (bit 12) is constant zero
  always_comb begin
    unique case (regSel_e'(regRdSel))
      SEL_VEC:  regRdData = {13'b0, vecMode, vecMask, 3'b0, 1'b0, 4'b0, vecNum};
      SEL_DIV:  regRdData = {28'b0, divBits[2], 1'b0, divBits[1:0]};
      SEL_INIT: regRdData = REG_W'(initCount);
      SEL_CUR:  regRdData = REG_W'(curCount);
      default:  regRdData = '0;
    endcase
  end
endmodule

// File: rtl/cpu_local_timer_dp.sv
module cpu_local_timer_dp
  import cpu_local_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  timerCfg_t        cfg,
  input  logic [CNT_W-1:0] wrValue,
  input  logic [CNT_W-1:0] initCount,
  output logic [CNT_W-1:0] curCount,
  output logic             irqValid,
  output logic [VEC_W-1:0] irqVector
);
  logic lastStep, expire, reload;

  always_comb begin
    lastStep = (curCount == CNT_W'(1));
    expire   = strobe.tick && lastStep;
    reload   = expire && (cfg.mode == MODE_PERIODIC);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curCount <= '0;
    end else if (strobe.clear) begin
      curCount <= '0;
    end else if (strobe.load) begin
      curCount <= wrValue;
    end else if (reload) begin
      curCount <= initCount;
    end else if (strobe.tick) begin
      curCount <= curCount - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqValid  <= 1'b0;
      irqVector <= '0;
    end else begin
      irqValid  <= expire && !cfg.vecMask;
      irqVector <= cfg.vecNum;
    end
  end
endmodule

// File: rtl/cpu_local_timer.sv
module cpu_local_timer
  import cpu_local_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regWrSel,
  input  logic [31:0] regWrData,
  input  logic [1:0]  regRdSel,
  output logic [31:0] regRdData,
  output logic        irqValid,
  output logic [7:0]  irqVector
);
  ctrlStrobe_t      strobe;
  timerCfg_t        cfg;
  logic [CNT_W-1:0] initCount;
  logic [CNT_W-1:0] curCount;

  cpu_local_timer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regWrSel(regWrSel), .regWrData(regWrData),
    .regRdSel(regRdSel), .curCount(curCount),
    .strobe(strobe), .cfg(cfg), .initCount(initCount), .regRdData(regRdData)
  );

  cpu_local_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .cfg(cfg),
    .wrValue(regWrData[CNT_W-1:0]), .initCount(initCount),
    .curCount(curCount), .irqValid(irqValid), .irqVector(irqVector)
  );
endmodule

// File: rtl/cpu_local_timer_chk.sv
module cpu_local_timer_chk
  import cpu_local_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [1:0]       regWrSel,
  input logic [31:0]      regWrData,
  input logic             irqValid,
  input logic [7:0]       irqVector,
  input timerCfg_t        cfg,
  input logic [CNT_W-1:0] curCount
);
  logic initWr;
  assign initWr = regWrEn && (regWrSel == 2'd2);

  AST_LOAD_START: assert property (@(posedge clk) disable iff (!rstN)
    (initWr && regWrData[CNT_W-1:0] != '0) |=> curCount == $past(regWrData[CNT_W-1:0])); // R5

  AST_ZERO_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (initWr && regWrData[CNT_W-1:0] == '0) |=> curCount == '0); // R6

  AST_IDLE_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (curCount == '0 && !initWr) |=> curCount == '0); // R7

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> !$past(cfg.vecMask)); // R9

  AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    irqValid |-> irqVector == $past(cfg.vecNum)); // R9

  AST_FROZEN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.mode[1] && $past(cfg.mode[1])) |-> !irqValid); // R11

  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.mode[1] && !initWr) |=> $stable(curCount)); // R11
endmodule

bind cpu_local_timer cpu_local_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrSel(regWrSel),
  .regWrData(regWrData), .irqValid(irqValid), .irqVector(irqVector),
  .cfg(cfg), .curCount(curCount)
);

// File: tb/cpu_local_timer_bench.sv
module cpu_local_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regWrSel = 2'd0;
  logic [31:0] regWrData = '0;
  logic [1:0]  regRdSel = 2'd0;
  logic [31:0] regRdData;
  logic        irqValid;
  logic [7:0]  irqVector;

  int nChecks = 0;
  int nFails = 0;
  int cycCount = 0;
  bit done = 1'b0;

  int        expCyc[$];
  logic [7:0] expVec[$];
  string     expTag[$];

  cpu_local_timer u_cpu_local_timer (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrSel(regWrSel),
    .regWrData(regWrData), .regRdSel(regRdSel), .regRdData(regRdData),
    .irqValid(irqValid), .irqVector(irqVector)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycCount <= cycCount + 1;

  // driver tasks, called at a falling edge
  task automatic wrReg(input logic [1:0] sel, input logic [31:0] d, output int capCyc);
    regWrEn = 1'b1; regWrSel = sel; regWrData = d;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
    capCyc = cycCount;
  endtask

  task automatic expectIrq(input int cyc, input logic [7:0] v, input string tag);
    expCyc.push_back(cyc); expVec.push_back(v); expTag.push_back(tag);
  endtask

  task automatic chkRead(input logic [1:0] sel, input logic [31:0] expd, input string tag);
    regRdSel = sel;
    #1;
    nChecks++;
    if (regRdData !== expd) begin
      nFails++;
      $display("FAIL %s read sel %0d: actual %h expected %h", tag, sel, regRdData, expd);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitUntil(input int c);
    while (cycCount < c) @(negedge clk);
  endtask

  // monitor: compares requests against the scoreboard queue
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (expCyc.size() > 0 && expCyc[0] < cycCount) begin
        nChecks++; nFails++;
        $display("FAIL %s missed request: actual none expected cycle %0d vector %h",
                 expTag[0], expCyc[0], expVec[0]);
        void'(expCyc.pop_front()); void'(expVec.pop_front()); void'(expTag.pop_front());
      end
      if (irqValid) begin
        nChecks++;
        if (expCyc.size() == 0) begin
          nFails++;
          $display("FAIL R9 unexpected request: actual cycle %0d vector %h expected none",
                   cycCount, irqVector);
        end else begin
          if (expCyc[0] != cycCount || expVec[0] !== irqVector) begin
            nFails++;
            $display("FAIL %s request: actual cycle %0d vector %h expected cycle %0d vector %h",
                     expTag[0], cycCount, irqVector, expCyc[0], expVec[0]);
          end
          void'(expCyc.pop_front()); void'(expVec.pop_front()); void'(expTag.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int c0;
    int c1;
    int w;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);

    // R1 reset values
    chkRead(2'd0, 32'h0001_0000, "R1");
    chkRead(2'd1, 32'h0, "R1");
    chkRead(2'd2, 32'h0, "R1");
    chkRead(2'd3, 32'h0, "R1");

    // R2, R3 field masks; mode 3 leaves the load frozen (R11)
    wrReg(2'd0, 32'hFFFF_FFFF, c0);
    chkRead(2'd0, 32'h0007_00FF, "R2");
    wrReg(2'd1, 32'hFFFF_FFFF, c0);
    chkRead(2'd1, 32'h0000_000B, "R3");
    wrReg(2'd2, 32'hA5A5_0000, c0);
    waitCyc(10);
    chkRead(2'd3, 32'hA5A5_0000, "R11");
    chkRead(2'd2, 32'hA5A5_0000, "R5");
    wrReg(2'd2, 32'h0, c0);
    chkRead(2'd3, 32'h0, "R6");
    wrReg(2'd3, 32'h0000_1234, c0);
    chkRead(2'd3, 32'h0, "R12");
    chkRead(2'd2, 32'h0, "R12");

    // R7 one-shot with divide-by-one
    wrReg(2'd0, 32'h0000_0040, c0);
    wrReg(2'd1, 32'h0000_000B, c0);
    wrReg(2'd2, 32'd5, c0);
    expectIrq(c0 + 5, 8'h40, "R7");
    waitCyc(1);
    chkRead(2'd3, 32'd4, "R5");
    waitCyc(20);
    chkRead(2'd3, 32'd0, "R7");

    // R4 divide mapping: {write, count, period}
    begin
      int dw[5] = '{0, 2, 8, 3, 9};
      int nn[5] = '{3, 2, 2, 2, 1};
      int pp[5] = '{2, 8, 32, 16, 64};
      for (int i = 0; i < 5; i++) begin
        wrReg(2'd1, dw[i], c0);
        wrReg(2'd2, nn[i], c0);
        expectIrq(c0 + nn[i] * pp[i], 8'h40, "R4");
        waitCyc(nn[i] * pp[i] + 5);
      end
    end

    // R8 periodic, then R6 stop
    wrReg(2'd0, 32'h0002_0033, c0);
    wrReg(2'd1, 32'h0000_000B, c0);
    wrReg(2'd2, 32'd4, c0);
    expectIrq(c0 + 4, 8'h33, "R8");
    expectIrq(c0 + 8, 8'h33, "R8");
    expectIrq(c0 + 12, 8'h33, "R8");
    waitUntil(c0 + 13);
    wrReg(2'd2, 32'd0, c1);
    chkRead(2'd3, 32'd0, "R6");
    waitCyc(12);

    // R9 masked: count runs, no request
    wrReg(2'd0, 32'h0001_0050, c0);
    wrReg(2'd2, 32'd3, c0);
    waitCyc(10);
    chkRead(2'd3, 32'd0, "R9");

    // R10 divide change at the next boundary
    wrReg(2'd0, 32'h0000_0041, c0);
    wrReg(2'd1, 32'h0000_0000, c0);
    wrReg(2'd2, 32'd4, c0);
    waitUntil(c0 + 2);
    wrReg(2'd1, 32'h0000_000B, c1);
    expectIrq(c0 + 6, 8'h41, "R10");
    waitCyc(10);

    // R11 deadline mode freezes, one-shot resumes
    wrReg(2'd0, 32'h0004_0060, c0);
    wrReg(2'd2, 32'd5, c0);
    waitCyc(20);
    chkRead(2'd3, 32'd5, "R11");
    wrReg(2'd0, 32'h0000_0060, w);
    expectIrq(w + 5, 8'h60, "R11");
    waitCyc(10);
    chkRead(2'd3, 32'd0, "R7");

    waitCyc(5);
    nChecks++;
    if (expCyc.size() != 0) begin
      nFails++;
      $display("FAIL R9 pending requests: actual %0d outstanding expected 0", expCyc.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule